// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits in front of the page load controller of a byte-wide nonvolatile memory. It watches every byte-load cycle, which is an address and a data byte presented for one clock with `ld_valid`, and recognises the multi-cycle unlock commands. Each command opens with the key byte AAH written to address 5555H and then 55H written to 2AAAH. Only address bits 14..0 take part in the comparison. A third cycle at 5555H either finishes a short command or selects the extended form. The extended form repeats the two key cycles and then takes a final operation byte.

The decoder owns a global protect bit. That bit models the nonvolatile write-protect flag, and only the protect and unprotect commands change it. The decoder also owns an identification-mode flag, which turns reads at the two lowest addresses into maker and device codes. It issues a one-cycle chip-erase start pulse and holds a shared busy timer. The timer covers the erase, the ID transitions and the lockout that follows a rejected write. Cycles that are ordinary data go out on the `fwd_*` port, registered, to the page load controller.

The FSM has seven states. `ST_IDLE` waits for key 1. `ST_K1` means key 1 has been seen. `ST_K2` means both keys have been seen and the third cycle is the operation byte. `ST_X3`, `ST_X4` and `ST_X5` hold the second key pair and the final byte of the extended form. `ST_PAGE` is the permitted page-load window.

The transitions are as follows:
- `ST_IDLE`→`ST_K1` on key 1.
- `ST_K1`→`ST_K2` on key 2.
- `ST_K2`→`ST_PAGE` on A0H.
- `ST_K2`→`ST_X3` on 80H.
- `ST_K2`→`ST_IDLE` on 90H or F0H.
- `ST_X3`→`ST_X4` on key 1.
- `ST_X4`→`ST_X5` on key 2.
- `ST_X5`→`ST_IDLE` on 20H, 10H or 60H.
- `ST_PAGE`→`ST_PAGE` on any load.
- `ST_PAGE`→`ST_IDLE` when the window expires.
- Any state other than `ST_PAGE`→`ST_IDLE` on a mismatching cycle.

Top module: `uls_decoder`

## Requirements
- R1: After reset, `prot_on`, `id_mode`, `page_permit`, `busy`, `fwd_valid` and `erase_start` are all 0.
- R2: A command opens with AAH at 5555H and then 55H at 2AAAH. Address bit 15 is ignored in the comparison, so D555H and AAAAH also match.
- R3: The short command with third byte A0H sets `prot_on` and `page_permit` one cycle after the load. Every load inside the window is forwarded and restarts the window. `page_permit` stays high for WIN_CYC+1 cycles after the last load and then drops, and `prot_on` stays 1.
- R4: While `prot_on` is 1, a load outside an unlock sequence or the page window is discarded. No `fwd_valid` follows it, and `busy` is raised for LOCK_CYC cycles. Any load presented while `busy` is 1 is ignored completely.
- R5: The extended command with final byte 20H clears `prot_on`. After that, ordinary loads are forwarded again.
- R6: The extended command with final byte 10H produces `erase_start` high for exactly one cycle and `busy` high for ERASE_CYC cycles.
- R7: Identification mode is entered by the short command with 90H or by the extended command with 60H, and the entry raises `busy` for ID_CYC cycles. In ID mode, when `id_rd_addr[14:1]` is 0, `id_hit` is 1 and `id_data` is BFH for `id_rd_addr[0]`=0 and DEV_CODE for `id_rd_addr[0]`=1. At any other address, or outside ID mode, `id_hit` is 0.
- R8: The short command with F0H clears `id_mode` and raises `busy` for ID_CYC cycles. `id_mode` never changes in a cycle without a load.
- R9: A cycle that does not match the expected step returns the FSM to `ST_IDLE`. With protection off, that cycle appears on `fwd_*` one cycle later. Cycles consumed as command steps are never forwarded.
- R10: Reset clears `id_mode` even when it was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Byte-load cycle strobe |
| ld_addr | input | 16 | Byte-load address |
| ld_data | input | 8 | Byte-load data |
| id_rd_addr | input | 15 | Read address used for identification lookup |
| fwd_valid | output | 1 | Forwarded byte load for the page load controller |
| fwd_addr | output | 16 | Forwarded address |
| fwd_data | output | 8 | Forwarded data |
| page_permit | output | 1 | Unlocked page-load window open |
| prot_on | output | 1 | Global write-protect state |
| id_mode | output | 1 | Identification mode active |
| id_hit | output | 1 | Read address maps to an ID byte |
| id_data | output | 8 | ID byte for `id_rd_addr` |
| erase_start | output | 1 | One-cycle chip-erase start pulse |
| busy | output | 1 | Erase, ID transition or lockout timer running |

## Verification
A wrong FSM state usually shows up as a missing or extra `fwd_valid` one cycle after a load. Where no forward is expected, it shows as `busy` rising from a lockout one cycle after the next cycle, which a correct state would have accepted. Each check therefore follows the suspect load with a probe load. A dropped ignore-while-busy rule is exposed the same way: the ignored key byte, if wrongly taken, turns the following key-2 cycle into a progress step instead of a second lockout. Timer errors are caught by counting the exact number of busy or permit cycles.

// File: rtl/uls_pkg.sv
package uls_pkg;

    localparam logic [14:0] ADDR_A = 15'h5555;
    localparam logic [14:0] ADDR_B = 15'h2AAA;

    localparam logic [7:0] KEY1      = 8'hAA;
    localparam logic [7:0] KEY2      = 8'h55;
    localparam logic [7:0] OP_PAGE   = 8'hA0;
    localparam logic [7:0] OP_EXT    = 8'h80;
    localparam logic [7:0] OP_IDIN   = 8'h90;
    localparam logic [7:0] OP_IDOUT  = 8'hF0;
    localparam logic [7:0] OP_UNPROT = 8'h20;
    localparam logic [7:0] OP_ERASE  = 8'h10;
    localparam logic [7:0] OP_IDIN6  = 8'h60;
    localparam logic [7:0] MFR_CODE  = 8'hBF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_K1,
        ST_K2,
        ST_X3,
        ST_X4,
        ST_X5,
        ST_PAGE
    } seq_state_e;

    typedef enum logic [3:0] {
        TK_OTHER,
        TK_KEY1,
        TK_KEY2,
        TK_PAGE,
        TK_EXT,
        TK_IDIN,
        TK_IDOUT,
        TK_UNPROT,
        TK_ERASE,
        TK_IDIN6
    } token_e;

endpackage

// File: rtl/uls_token_match.sv
module uls_token_match
    import uls_pkg::*;
(
    input  logic [14:0] addr,
    input  logic [7:0]  data,
    output token_e      tok
);
    always_comb begin
        tok = TK_OTHER;
        if (addr == ADDR_B) begin
            if (data == KEY2) tok = TK_KEY2;
        end else if (addr == ADDR_A) begin
            unique case (data)
                KEY1:      tok = TK_KEY1;
                OP_PAGE:   tok = TK_PAGE;
                OP_EXT:    tok = TK_EXT;
                OP_IDIN:   tok = TK_IDIN;
                OP_IDOUT:  tok = TK_IDOUT;
                OP_UNPROT: tok = TK_UNPROT;
                OP_ERASE:  tok = TK_ERASE;
                OP_IDIN6:  tok = TK_IDIN6;
                default:   tok = TK_OTHER;
            endcase
        end
    end
endmodule

// File: rtl/uls_countdown.sv
module uls_countdown #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] load_val,
    output logic          active
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active = (cnt_q != '0);

    // Once running without a restart, the count only goes down (R4, R6, R8 timing)
    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/uls_id_rom.sv
module uls_id_rom
    import uls_pkg::*;
#(
    parameter logic [7:0] DEV_CODE = 8'h5D
) (
    input  logic        id_mode,
    input  logic [14:0] rd_addr,
    output logic        id_hit,
    output logic [7:0]  id_data
);
    always_comb begin
        id_hit  = id_mode && (rd_addr[14:1] == '0);
        id_data = 8'h00;
        if (id_hit) id_data = rd_addr[0] ? DEV_CODE : MFR_CODE;
    end
endmodule

// File: rtl/uls_decoder.sv
module uls_decoder
    import uls_pkg::*;
#(
    parameter int unsigned ERASE_CYC = 2000000,
    parameter int unsigned ID_CYC    = 1000,
    parameter int unsigned LOCK_CYC  = 30000,
    parameter int unsigned WIN_CYC   = 20000,
    parameter logic [7:0]  DEV_CODE  = 8'h5D
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld_valid,
    input  logic [15:0] ld_addr,
    input  logic [7:0]  ld_data,
    input  logic [14:0] id_rd_addr,
    output logic        fwd_valid,
    output logic [15:0] fwd_addr,
    output logic [7:0]  fwd_data,
    output logic        page_permit,
    output logic        prot_on,
    output logic        id_mode,
    output logic        id_hit,
    output logic [7:0]  id_data,
    output logic        erase_start,
    output logic        busy
);
    localparam int unsigned MAX_A = (ERASE_CYC > ID_CYC) ? ERASE_CYC : ID_CYC;
    localparam int unsigned BMAX  = (MAX_A > LOCK_CYC) ? MAX_A : LOCK_CYC;
    localparam int BW = $clog2(BMAX + 1);
    localparam int WW = $clog2(WIN_CYC + 1);

    seq_state_e state_q, state_d;
    token_e     tok;
    logic       act;
    logic       miss, set_prot, clr_prot, id_set, id_clr;
    logic       erase_go, id_go, lock_go, fwd_go, win_go;
    logic       win_open;
    logic [BW-1:0] busy_load;

    uls_token_match u_match (
        .addr (ld_addr[14:0]),
        .data (ld_data),
        .tok  (tok)
    );

    assign act = ld_valid && !busy;

    // Next state and per-cycle actions
    always_comb begin
        state_d  = state_q;
        miss     = 1'b0;
        set_prot = 1'b0;
        clr_prot = 1'b0;
        id_set   = 1'b0;
        id_clr   = 1'b0;
        erase_go = 1'b0;
        id_go    = 1'b0;
        fwd_go   = 1'b0;
        win_go   = 1'b0;
        unique case (state_q)
            ST_IDLE: if (act) begin
                if (tok == TK_KEY1) state_d = ST_K1;
                else                miss    = 1'b1;
            end
            ST_K1: if (act) begin
                if (tok == TK_KEY2) state_d = ST_K2;
                else                miss    = 1'b1;
            end
            ST_K2: if (act) begin
                unique case (tok)
                    TK_PAGE:  begin set_prot = 1'b1; win_go = 1'b1; state_d = ST_PAGE; end
                    TK_EXT:   state_d = ST_X3;
                    TK_IDIN:  begin id_set = 1'b1; id_go = 1'b1; state_d = ST_IDLE; end
                    TK_IDOUT: begin id_clr = 1'b1; id_go = 1'b1; state_d = ST_IDLE; end
                    default:  miss = 1'b1;
                endcase
            end
            ST_X3: if (act) begin
                if (tok == TK_KEY1) state_d = ST_X4;
                else                miss    = 1'b1;
            end
            ST_X4: if (act) begin
                if (tok == TK_KEY2) state_d = ST_X5;
                else                miss    = 1'b1;
            end
            ST_X5: if (act) begin
                unique case (tok)
                    TK_UNPROT: begin clr_prot = 1'b1; state_d = ST_IDLE; end
                    TK_ERASE:  begin erase_go = 1'b1; state_d = ST_IDLE; end
                    TK_IDIN6:  begin id_set = 1'b1; id_go = 1'b1; state_d = ST_IDLE; end
                    default:   miss = 1'b1;
                endcase
            end
            ST_PAGE: begin
                if (act) begin
                    fwd_go = 1'b1;
                    win_go = 1'b1;
                end else if (!win_open) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (miss) begin
            state_d = ST_IDLE;
            fwd_go  = !prot_on;
        end
    end

    assign lock_go = miss && prot_on;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_on     <= 1'b0;
            id_mode     <= 1'b0;
            fwd_valid   <= 1'b0;
            fwd_addr    <= '0;
            fwd_data    <= '0;
            erase_start <= 1'b0;
        end else begin
            if (set_prot)      prot_on <= 1'b1;
            else if (clr_prot) prot_on <= 1'b0;
            if (id_set)        id_mode <= 1'b1;
            else if (id_clr)   id_mode <= 1'b0;
            fwd_valid   <= fwd_go;
            erase_start <= erase_go;
            if (fwd_go) begin
                fwd_addr <= ld_addr;
                fwd_data <= ld_data;
            end
        end
    end

    assign page_permit = (state_q == ST_PAGE);

    always_comb begin
        if (erase_go)   busy_load = BW'(ERASE_CYC);
        else if (id_go) busy_load = BW'(ID_CYC);
        else            busy_load = BW'(LOCK_CYC);
    end

    uls_countdown #(.CW(BW)) u_busy_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (erase_go || id_go || lock_go),
        .load_val (busy_load),
        .active   (busy)
    );

    uls_countdown #(.CW(WW)) u_win_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (win_go),
        .load_val (WW'(WIN_CYC)),
        .active   (win_open)
    );

    uls_id_rom #(.DEV_CODE(DEV_CODE)) u_id_rom (
        .id_mode (id_mode),
        .rd_addr (id_rd_addr),
        .id_hit  (id_hit),
        .id_data (id_data)
    );

    p_permit_needs_prot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        page_permit |-> prot_on);

    p_fwd_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (!prot_on || page_permit));

    p_erase_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> (!erase_start && busy));

    p_id_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> $stable(id_mode));

    p_fwd_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(ld_valid));
endmodule

// File: tb/uls_decoder_bench.sv
module uls_decoder_bench;
    localparam int ERASE_N = 50;
    localparam int ID_N    = 6;
    localparam int LOCK_N  = 12;
    localparam int WIN_N   = 8;
    localparam logic [7:0] DEV = 8'h5D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [15:0] ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic [14:0] id_rd_addr = '0;
    logic        fwd_valid, page_permit, prot_on, id_mode, id_hit, erase_start, busy;
    logic [15:0] fwd_addr;
    logic [7:0]  fwd_data, id_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    uls_decoder #(
        .ERASE_CYC (ERASE_N),
        .ID_CYC    (ID_N),
        .LOCK_CYC  (LOCK_N),
        .WIN_CYC   (WIN_N),
        .DEV_CODE  (DEV)
    ) u_uls_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_valid    (ld_valid),
        .ld_addr     (ld_addr),
        .ld_data     (ld_data),
        .id_rd_addr  (id_rd_addr),
        .fwd_valid   (fwd_valid),
        .fwd_addr    (fwd_addr),
        .fwd_data    (fwd_data),
        .page_permit (page_permit),
        .prot_on     (prot_on),
        .id_mode     (id_mode),
        .id_hit      (id_hit),
        .id_data     (id_data),
        .erase_start (erase_start),
        .busy        (busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_addr  = a;
        ld_data  = d;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic keys();
        do_load(16'h5555, 8'hAA);
        do_load(16'h2AAA, 8'h55);
    endtask

    task automatic ext_cmd(input logic [7:0] op);
        keys();
        do_load(16'h5555, 8'h80);
        keys();
        do_load(16'h5555, op);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R1 prot_on", prot_on, 0);
        check("R1 id_mode", id_mode, 0);
        check("R1 page_permit", page_permit, 0);
        check("R1 busy", busy, 0);
        check("R1 fwd_valid", fwd_valid, 0);
        check("R1 erase_start", erase_start, 0);
    endtask

    task automatic t_plain();
        do_load(16'h1234, 8'h5A);
        check("R9 plain fwd_valid", fwd_valid, 1);
        check("R9 plain fwd_addr", fwd_addr, 16'h1234);
        check("R9 plain fwd_data", fwd_data, 8'h5A);
    endtask

    task automatic t_consumed();
        do_load(16'h5555, 8'hAA);
        check("R9 key not forwarded", fwd_valid, 0);
        do_load(16'h0100, 8'h33);
        check("R9 mismatch forwarded", fwd_valid, 1);
        check("R9 mismatch data", fwd_data, 8'h33);
        check("R9 no lockout when unprotected", busy, 0);
    endtask

    task automatic t_bad_third();
        keys();
        check("R9 key2 not forwarded", fwd_valid, 0);
        do_load(16'h5555, 8'h33);
        check("R9 bad third forwarded", fwd_valid, 1);
        check("R9 bad third addr", fwd_addr, 16'h5555);
        check("R9 prot unchanged", prot_on, 0);
    endtask

    task automatic t_protect();
        int n;
        do_load(16'hD555, 8'hAA);
        do_load(16'hAAAA, 8'h55);
        do_load(16'h5555, 8'hA0);
        check("R2 bit15 ignored, R3 prot_on", prot_on, 1);
        check("R3 page_permit", page_permit, 1);
        check("R3 cmd not forwarded", fwd_valid, 0);
        for (int i = 0; i < 3; i++) begin
            do_load(16'h0300 + 16'(i), 8'hC0 + 8'(i));
            check("R3 page fwd_valid", fwd_valid, 1);
            check("R3 page fwd_data", fwd_data, 8'hC0 + i);
        end
        n = 0;
        while (page_permit && n < 100) begin
            n++;
            @(negedge clk);
        end
        check("R3 window length", n, WIN_N + 1);
        check("R3 stays protected", prot_on, 1);
    endtask

    task automatic t_discard();
        int n;
        do_load(16'h0400, 8'h77);
        check("R4 discarded", fwd_valid, 0);
        check("R4 lockout busy", busy, 1);
        do_load(16'h5555, 8'hAA);
        check("R4 load while busy not forwarded", fwd_valid, 0);
        count_busy(n);
        check("R4 lockout length", n, LOCK_N - 2);
        do_load(16'h2AAA, 8'h55);
        check("R4 busy load ignored, key2 now rejected", busy, 1);
        check("R4 no permit", page_permit, 0);
        count_busy(n);
    endtask

    task automatic t_unprotect();
        ext_cmd(8'h20);
        check("R5 prot cleared", prot_on, 0);
        check("R5 busy after unprotect", busy, 0);
        do_load(16'h0500, 8'h99);
        check("R5 ordinary load forwarded", fwd_valid, 1);
        check("R5 data", fwd_data, 8'h99);
    endtask

    task automatic t_id();
        int n;
        keys();
        do_load(16'h5555, 8'h90);
        check("R7 id entry", id_mode, 1);
        count_busy(n);
        check("R7 id entry busy", n, ID_N);
        id_rd_addr = 15'h0000; #1;
        check("R7 hit at 0", id_hit, 1);
        check("R7 maker code", id_data, 8'hBF);
        id_rd_addr = 15'h0001; #1;
        check("R7 device code", id_data, DEV);
        id_rd_addr = 15'h0101; #1;
        check("R7 no hit at 0101", id_hit, 0);
        keys();
        do_load(16'h5555, 8'hF0);
        check("R8 id exit", id_mode, 0);
        count_busy(n);
        check("R8 id exit busy", n, ID_N);
        id_rd_addr = 15'h0000; #1;
        check("R7 no hit outside id", id_hit, 0);
        ext_cmd(8'h60);
        check("R7 six-cycle id entry", id_mode, 1);
        count_busy(n);
        repeat (3) @(negedge clk);
        check("R8 id stable without load", id_mode, 1);
    endtask

    task automatic t_reset_id();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 id cleared by reset", id_mode, 0);
    endtask

    task automatic t_erase();
        int n;
        ext_cmd(8'h10);
        check("R6 erase pulse", erase_start, 1);
        check("R6 busy", busy, 1);
        @(negedge clk);
        check("R6 pulse one cycle", erase_start, 0);
        count_busy(n);
        check("R6 erase busy length", n + 1, ERASE_N);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_consumed();
        t_bad_third();
        t_protect();
        t_discard();
        t_unprotect();
        t_erase();
        t_id();
        t_reset_id();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule